// File: doc/BRIEF.md
# Strided DMA Address Generator

This block walks the byte addresses for one side of a DMA channel, either the read side or the write side. A start pulse captures a job: a start address, a stepping mode, an element width, a per-frame element count, a frame count, and two signed byte offsets. One offset is applied after every element. The other is applied once after the last element of each frame. Each advance strobe consumes the current address, and the block then moves to the next one.

Alongside the address, the block flags the last element of the current frame and the last element of the whole job. The job holds `frames × elements-per-frame` elements, which is `element width × elements × frames` bytes.

The block rejects a bad job with a one-cycle error pulse and does not start it. A job is bad if its mode code is unknown, or if the alignment check is enabled and the start address is not a multiple of the element width. A job with an empty count finishes at once: done pulses and no address is issued. Data movement, bus protocol, arbitration and descriptor fetch belong to the surrounding channel.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all low.
- R2: A start pulse taken while idle with a legal job and non-zero counts raises `busy` on the next cycle, and `addr_o` then equals the start address.
- R3: Mode code 0 (hold) presents the same address for every element.
- R4: Mode code 1 (ascend) adds the element width in bytes to the address after each element. The width field is the base-2 log of that byte count: 0→1, 1→2, 2→4, 3→8.
- R5: Mode code 2 (descend) subtracts the element width from the address after each element.
- R6: Mode code 3 (linear stride) adds the element width plus the signed element offset after each element.
- R7: Mode code 4 (planar stride) adds the element width plus the signed element offset after each element. After the last element of a frame it also adds the signed frame offset.
- R8: `last_frame` is high while the last element of a frame is presented. `last_xfer` is high only while the final element of the job is presented, and the job issues exactly frames × elements-per-frame addresses.
- R9: `done` pulses for exactly one cycle, in the cycle after the advance that consumes the final element, and `busy` falls in that same cycle.
- R10: A start with a zero element count or a zero frame count pulses `done` on the next cycle, and `busy` stays low.
- R11: When `cfg_align_en` is high, a start address that is not a multiple of the element width pulses `err` for one cycle and the job does not start. When `cfg_align_en` is low, the same address is accepted.
- R12: Mode codes 5, 6 and 7 pulse `err` for one cycle and the job does not start.
- R13: Address arithmetic is 32-bit and wraps modulo 2^32.
- R14: A start pulse during a job has no effect on it, and an advance strobe while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture the job and begin (ignored while busy) |
| cfg_addr | input | 32 | Start byte address |
| cfg_mode | input | 3 | Stepping mode code |
| cfg_esize | input | 2 | log2 of element width in bytes |
| cfg_epf | input | 16 | Elements per frame |
| cfg_fpt | input | 16 | Frames per job |
| cfg_eskip | input | 32 | Signed element offset in bytes |
| cfg_fskip | input | 32 | Signed frame offset in bytes |
| cfg_align_en | input | 1 | Reject start addresses not aligned to the element width |
| adv | input | 1 | Consume the current address |
| addr_o | output | 32 | Current address |
| last_frame | output | 1 | Current element ends a frame |
| last_xfer | output | 1 | Current element ends the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at job end |
| err | output | 1 | One-cycle pulse on a rejected job |

## Verification
The assertions rely on the configuration inputs being stable in the cycle that `start` is high. They also take `adv` to matter only while `busy` is high, and `start` to be a single-cycle pulse. The stepping checks look only at advances that are not the job's last, so they never compare against an address taken from an idle period. The bench drives every input on the falling clock edge. It holds each job's configuration for the whole start cycle, and it deliberately pulses `start` during a job and `adv` while idle to exercise R14.

// File: rtl/dag_pkg.sv
// Shared types for the strided DMA address generator.
// Assumes mode codes 0..4 are legal and everything above them is not.
package dag_pkg;
    typedef enum logic [2:0] {
        AM_HOLD    = 3'd0,
        AM_ASCEND  = 3'd1,
        AM_DESCEND = 3'd2,
        AM_STRIDE1 = 3'd3,
        AM_STRIDE2 = 3'd4
    } addr_mode_e;

    // True when the mode code names a supported stepping rule.
    function automatic logic mode_legal(input logic [2:0] m);
        return m <= 3'd4;
    endfunction
endpackage

// File: rtl/dag_stepper.sv
// Computes the next address from the current one.
// Assumes skips are two's complement of ADDR_W bits; results wrap modulo 2^ADDR_W.
module dag_stepper
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  addr_mode_e        mode,
    input  logic [1:0]        esize_log2,
    input  logic [ADDR_W-1:0] eskip,
    input  logic [ADDR_W-1:0] fskip,
    input  logic              frame_end,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] width_b;

    // Element width in bytes from its log2 code.
    always_comb width_b = ADDR_W'(1) << esize_log2;

    // Select the stepping rule for the current mode.
    always_comb begin
        case (mode)
            AM_ASCEND:  nxt_addr = cur_addr + width_b;
            AM_DESCEND: nxt_addr = cur_addr - width_b;
            AM_STRIDE1: nxt_addr = cur_addr + width_b + eskip;
            AM_STRIDE2: nxt_addr = cur_addr + width_b + eskip
                                   + (frame_end ? fskip : '0);
            default:    nxt_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/dag_counter.sv
// Wrapping position counter with a run-time limit.
// Assumes limit is non-zero while inc may be asserted; clr wins over inc.
module dag_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    // Flag the final position of the range.
    always_comb at_last = (cnt == limit - CNT_W'(1));

    // Count up, returning to zero after the final position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end
endmodule

// File: rtl/dma_addr_gen.sv
// Top of the strided DMA address generator: accepts a job, checks it,
// then steps an address on each advance strobe until all elements are used.
// Assumes cfg_* are valid in the start cycle; start is ignored while busy.
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [2:0]        cfg_mode,
    input  logic [1:0]        cfg_esize,
    input  logic [CNT_W-1:0]  cfg_epf,
    input  logic [CNT_W-1:0]  cfg_fpt,
    input  logic [ADDR_W-1:0] cfg_eskip,
    input  logic [ADDR_W-1:0] cfg_fskip,
    input  logic              cfg_align_en,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_frame,
    output logic              last_xfer,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic [ADDR_W-1:0] addr_q, eskip_q, fskip_q, nxt_addr;
    logic [CNT_W-1:0]  epf_q, fpt_q, ecnt, fcnt;
    logic [1:0]        esize_q;
    addr_mode_e        mode_q;
    logic              busy_q, done_q, err_q;
    logic              elem_last, frm_last, step, cfg_bad, cfg_empty;
    logic [ADDR_W-1:0] align_mask;

    // Decode job legality and emptiness at start time.
    always_comb begin
        align_mask = (ADDR_W'(1) << cfg_esize) - ADDR_W'(1);
        cfg_bad    = !mode_legal(cfg_mode) ||
                     (cfg_align_en && ((cfg_addr & align_mask) != '0));
        cfg_empty  = (cfg_epf == '0) || (cfg_fpt == '0);
    end

    // An advance only counts while a job runs.
    always_comb step = busy_q && adv;

    dag_counter #(.CNT_W(CNT_W)) u_elem_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!busy_q), .inc(step),
        .limit(epf_q), .cnt(ecnt), .at_last(elem_last)
    );

    dag_counter #(.CNT_W(CNT_W)) u_frm_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!busy_q), .inc(step && elem_last),
        .limit(fpt_q), .cnt(fcnt), .at_last(frm_last)
    );

    dag_stepper #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr(addr_q), .mode(mode_q), .esize_log2(esize_q),
        .eskip(eskip_q), .fskip(fskip_q), .frame_end(elem_last),
        .nxt_addr(nxt_addr)
    );

    // Job control: accept or reject, step, and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            eskip_q <= '0;
            fskip_q <= '0;
            epf_q   <= '0;
            fpt_q   <= '0;
            esize_q <= '0;
            mode_q  <= AM_HOLD;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (cfg_bad)        err_q  <= 1'b1;
                    else if (cfg_empty) done_q <= 1'b1;
                    else begin
                        busy_q  <= 1'b1;
                        addr_q  <= cfg_addr;
                        mode_q  <= addr_mode_e'(cfg_mode);
                        esize_q <= cfg_esize;
                        eskip_q <= cfg_eskip;
                        fskip_q <= cfg_fskip;
                        epf_q   <= cfg_epf;
                        fpt_q   <= cfg_fpt;
                    end
                end
            end else if (adv) begin
                if (elem_last && frm_last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    addr_q <= nxt_addr;
                end
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        addr_o     = addr_q;
        last_frame = busy_q && elem_last;
        last_xfer  = busy_q && elem_last && frm_last;
        busy       = busy_q;
        done       = done_q;
        err        = err_q;
    end
endmodule

// File: rtl/dag_checker.sv
// Temporal checks on the address generator, attached by bind.
// Assumes start is a single-cycle pulse with cfg_* valid in that cycle.
module dag_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        cfg_mode,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_o,
    input logic              last_xfer,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [2:0]        mode_q,
    input logic [1:0]        esize_q
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_illegal_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_mode > 3'd4) |=> (err && !busy));

    p_err_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && !last_xfer && mode_q == 3'd0) |=> addr_o == $past(addr_o));

    p_ascend_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && !last_xfer && mode_q == 3'd1)
        |=> addr_o == $past(addr_o) + (ADDR_W'(1) << $past(esize_q)));

    p_busy_start_ignored_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !adv) |=> (busy && $stable(addr_o)));
endmodule

bind dma_addr_gen dag_checker #(.ADDR_W(ADDR_W)) u_dag_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode), .adv(adv),
    .addr_o(addr_o), .last_xfer(last_xfer), .busy(busy), .done(done),
    .err(err), .mode_q(mode_q), .esize_q(esize_q)
);

// File: tb/dma_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [2:0]  cfg_mode = '0;
    logic [1:0]  cfg_esize = '0;
    logic [15:0] cfg_epf = '0;
    logic [15:0] cfg_fpt = '0;
    logic [31:0] cfg_eskip = '0;
    logic [31:0] cfg_fskip = '0;
    logic        cfg_align_en = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] addr_o;
    logic        last_frame, last_xfer, busy, done, err;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dma_addr_gen u_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
        .cfg_mode(cfg_mode), .cfg_esize(cfg_esize), .cfg_epf(cfg_epf),
        .cfg_fpt(cfg_fpt), .cfg_eskip(cfg_eskip), .cfg_fskip(cfg_fskip),
        .cfg_align_en(cfg_align_en), .adv(adv), .addr_o(addr_o),
        .last_frame(last_frame), .last_xfer(last_xfer), .busy(busy),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a, input logic [2:0] m,
                        input logic [1:0] es, input int epf, input int fpt,
                        input logic [31:0] esk, input logic [31:0] fsk);
        cfg_addr = a; cfg_mode = m; cfg_esize = es;
        cfg_epf = 16'(epf); cfg_fpt = 16'(fpt);
        cfg_eskip = esk; cfg_fskip = fsk;
    endtask

    // Runs a full job and checks every address, both flags and the finish.
    task automatic run_xfer(input logic [31:0] a, input logic [2:0] m,
                            input logic [1:0] es, input int epf, input int fpt,
                            input logic [31:0] esk, input logic [31:0] fsk,
                            input int gap, input string tag);
        logic [31:0] e;
        logic [31:0] w;
        bit fl, xl;
        @(negedge clk);
        load(a, m, es, epf, fpt, esk, fsk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && addr_o === a, {tag, " R2 start"}, addr_o, a);
        e = a;
        w = 32'd1 << es;
        for (int f = 0; f < fpt; f++) begin
            for (int i = 0; i < epf; i++) begin
                for (int g = 0; g < gap; g++) @(negedge clk);
                fl = (i == epf - 1);
                xl = fl && (f == fpt - 1);
                chk(addr_o === e && last_frame === fl && last_xfer === xl,
                    {tag, " R8 element"}, addr_o, e);
                adv = 1'b1;
                @(negedge clk);
                adv = 1'b0;
                case (m)
                    3'd1: e = e + w;
                    3'd2: e = e - w;
                    3'd3: e = e + w + esk;
                    3'd4: e = e + w + esk + (fl ? fsk : 32'd0);
                    default: e = e;
                endcase
            end
        end
        chk(done === 1'b1 && busy === 1'b0, {tag, " R9 done"}, {30'd0, done, busy}, 32'h2);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R9 single"}, {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset",
            {29'd0, busy, done, err}, 32'd0);
    endtask

    task automatic t_modes();
        run_xfer(32'h0000_0100, 3'd0, 2'd2, 3, 2, 32'd0, 32'd0, 0, "R3 hold");
        run_xfer(32'h0000_1000, 3'd1, 2'd2, 4, 2, 32'd0, 32'd0, 1, "R4 ascend");
        run_xfer(32'h0000_2000, 3'd2, 2'd1, 3, 2, 32'd0, 32'd0, 0, "R5 descend");
        run_xfer(32'h0000_3000, 3'd3, 2'd2, 3, 2, 32'd12, 32'd0, 0, "R6 stride1");
        run_xfer(32'h0000_3000, 3'd3, 2'd3, 3, 1, -32'sd16, 32'd0, 0, "R6 negskip");
        run_xfer(32'h0000_4000, 3'd4, 2'd2, 3, 3, 32'd4, -32'sd64, 0, "R7 stride2");
        run_xfer(32'h0000_5000, 3'd4, 2'd0, 1, 4, 32'd0, 32'd100, 0, "R7 oneper");
    endtask

    task automatic t_wrap();
        run_xfer(32'hFFFF_FFF8, 3'd1, 2'd2, 4, 1, 32'd0, 32'd0, 0, "R13 wrapup");
        run_xfer(32'h0000_0004, 3'd2, 2'd2, 3, 1, 32'd0, 32'd0, 0, "R13 wrapdn");
    endtask

    task automatic t_empty(input int epf, input int fpt);
        @(negedge clk);
        load(32'h40, 3'd1, 2'd0, epf, fpt, 32'd0, 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R10 empty done", {30'd0, done, busy}, 32'h2);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 empty after", {30'd0, done, busy}, 32'h0);
    endtask

    task automatic t_reject(input logic [31:0] a, input logic [2:0] m, input string tag);
        @(negedge clk);
        load(a, m, 2'd2, 2, 1, 32'd0, 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err === 1'b1 && busy === 1'b0 && done === 1'b0, {tag, " err"},
            {29'd0, err, busy, done}, 32'h4);
        @(negedge clk);
        chk(err === 1'b0 && busy === 1'b0, {tag, " err single"}, {30'd0, err, busy}, 32'h0);
    endtask

    task automatic t_align();
        cfg_align_en = 1'b1;
        t_reject(32'h0000_0102, 3'd1, "R11 misaligned");
        run_xfer(32'h0000_0104, 3'd1, 2'd2, 2, 1, 32'd0, 32'd0, 0, "R11 aligned");
        cfg_align_en = 1'b0;
        run_xfer(32'h0000_0102, 3'd1, 2'd2, 2, 1, 32'd0, 32'd0, 0, "R11 unchecked");
    endtask

    task automatic t_illegal();
        for (int m = 5; m < 8; m++) t_reject(32'h0000_0200, 3'(m), "R12 illegal");
    endtask

    task automatic t_ignore();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            chk(busy === 1'b0 && done === 1'b0, "R14 idle adv", {30'd0, busy, done}, 32'h0);
        end
        @(negedge clk);
        load(32'h0000_2000, 3'd1, 2'd0, 2, 1, 32'd0, 32'd0);
        start = 1'b1;
        @(negedge clk);
        load(32'h0000_9000, 3'd0, 2'd3, 5, 5, 32'd0, 32'd0);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && addr_o === 32'h2000, "R14 busy start", addr_o, 32'h2000);
        adv = 1'b1;
        @(negedge clk);
        chk(addr_o === 32'h2001 && last_xfer === 1'b1, "R14 job kept", addr_o, 32'h2001);
        @(negedge clk);
        adv = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R14 job end", {30'd0, done, busy}, 32'h2);
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_wrap();
        t_empty(0, 3);
        t_empty(3, 0);
        t_align();
        t_illegal();
        t_ignore();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule